// File: doc/BRIEF.md
# I2C Register-Map Slave Controller

This block is a slave on a two-wire serial bus. It holds a small bank of byte-wide registers that a bus master reaches through a subaddress byte. SCL and SDA are brought into the system clock domain, cleaned of short pulses, and watched for start and stop conditions. When the 7-bit address that follows a start equals the block's own address, the block acknowledges it. It then either takes a subaddress and stores the data bytes that follow, or returns register contents from the current subaddress. In both cases the subaddress steps up by one after each byte.

The bus is open drain, so the block only ever pulls SDA low, through a drive enable. Every byte it stores also appears on a one-cycle write strobe with its address and data. The usual read is a write that sets the subaddress, then a repeated start with the read bit set. Subaddresses outside the map are refused. Writes that run past the top register are refused. Reads that run past the top keep returning the top register. A start or stop that arrives in the middle of a byte abandons that byte at once.

Top module: `i2c_regmap_slave`

## Requirements
- R1: After reset, sda_oe is 0, reg_we is 0 and every register reads back as 0x00.
- R2: After a start, the block shifts in 8 bits MSB first: a 7-bit address, then a R/W bit (0 = write, 1 = read). It pulls SDA low on the ninth SCL pulse only if the address equals DEV_ADDR (default 0x3C). On a mismatch it leaves SDA released and acknowledges nothing until the next start.
- R3: In a write, the first byte after the address is the subaddress, and it is acknowledged when it is below NUM_REGS (default 12). Each later byte is stored at the current subaddress, is acknowledged, and raises reg_we for exactly one clock with reg_addr and reg_wdata. The subaddress then goes up by one.
- R4: A subaddress byte of NUM_REGS or above is not acknowledged. The block goes idle, and later bytes up to the next start get no acknowledge and are not stored.
- R5: A write byte that arrives when the subaddress has passed the top register (NUM_REGS-1) is not stored and is not acknowledged, and the block goes idle.
- R6: In a read, the block sends the register at the current subaddress MSB first. After each master acknowledge (SDA low on the ninth pulse) it sends the next register.
- R7: A read that steps past the top register keeps returning register NUM_REGS-1. A master NACK (SDA high on the ninth pulse) ends the read, and the block then stops driving SDA.
- R8: A stop condition (SDA rising while SCL is high) at any point returns the block to idle. A partly received byte is discarded.
- R9: A start condition (SDA falling while SCL is high) at any point, repeated start included, restarts address reception.
- R10: sda_oe changes only while SCL is low.
- R11: A pulse on SCL shorter than FILT_LEN clocks (default 3) has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_we | output | 1 | One-cycle strobe for each stored byte |
| reg_addr | output | $clog2(NUM_REGS) | Register index of the stored byte |
| reg_wdata | output | 8 | Value of the stored byte |

## Verification
Each SCL and SDA input reaches the control logic about six clocks after it changes: two synchronizer stages, FILT_LEN filter cycles and one edge register. The bench holds each bus quarter-phase for 16 clocks. It reads acknowledge bits and read data in the middle of the SCL high phase, well after the slave's drive has settled. A store is due at the eighth falling edge of a data byte. So the expected write is queued before the byte is sent, and the per-clock monitor, sampling 2 ns after each rising edge, matches every reg_we pulse against that queue. The same monitor flags any change of sda_oe while the master holds SCL high.

// File: rtl/i2c_regmap_pkg.sv
package i2c_regmap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_SUB,
        ST_WDATA,
        ST_DACK,
        ST_RDATA,
        ST_RACK
    } slv_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic scl;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_LEN = 3,
    localparam int CW = $clog2(FILT_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    typedef struct packed {
        logic [1:0]    sync;
        logic          filt;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t d, q;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], line_i};
        if (q.sync[1] == q.filt) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(FILT_LEN - 1)) begin
            d.filt = q.sync[1];
            d.cnt  = '0;
        end else begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sync: 2'b11, filt: 1'b1, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign line_o = q.filt;

    // R11
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.filt) |-> (q.filt == $past(q.sync[1])));

endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond
    import i2c_regmap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t evt
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t d, q;

    always_comb begin
        d.scl = scl_f;
        d.sda = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        evt.scl      = scl_f;
        evt.sda      = sda_f;
        evt.scl_rise = scl_f & ~q.scl;
        evt.scl_fall = ~scl_f & q.scl;
        evt.start    = scl_f & q.scl & q.sda & ~sda_f;
        evt.stop     = scl_f & q.scl & ~q.sda & sda_f;
    end

endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
    parameter int NUM_REGS = 12,
    localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] regs_d [NUM_REGS];
    logic [7:0] regs_q [NUM_REGS];

    always_comb begin
        regs_d = regs_q;
        if (we && (int'(waddr) < NUM_REGS)) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= 8'h00;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata = (int'(raddr) < NUM_REGS) ? regs_q[raddr] : 8'h00;

    // R5
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < NUM_REGS));

    // R6
    rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(raddr) < NUM_REGS);

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_regmap_pkg::*;
#(
    parameter int         NUM_REGS = 12,
    parameter logic [6:0] DEV_ADDR = 7'h3C,
    localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int PW = $clog2(NUM_REGS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_evt_t      evt,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_idx,
    output logic          sda_oe,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [7:0]    wdata
);

    typedef struct packed {
        slv_state_e    st;
        logic [3:0]    cnt;
        logic [7:0]    sr;
        logic [7:0]    tx;
        logic [PW-1:0] ptr;
        logic          rw;
        logic          mack;
        logic          oe;
        logic          we;
        logic [AW-1:0] waddr;
        logic [7:0]    wdata;
    } fsm_t;

    fsm_t d, q;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (evt.stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (evt.start) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (evt.scl_rise && (q.cnt < 4'd8)) begin
                        d.sr  = {q.sr[6:0], evt.sda};
                        d.cnt = q.cnt + 4'd1;
                    end else if (evt.scl_fall && (q.cnt == 4'd8)) begin
                        d.st = ST_IDLE;
                        if (q.st == ST_ADDR) begin
                            if (q.sr[7:1] == DEV_ADDR) begin
                                d.rw = q.sr[0];
                                d.oe = 1'b1;
                                d.st = ST_AACK;
                            end
                        end else if (q.st == ST_SUB) begin
                            if (int'(q.sr) < NUM_REGS) begin
                                d.ptr = q.sr[PW-1:0];
                                d.oe  = 1'b1;
                                d.st  = ST_DACK;
                            end
                        end else begin
                            if (int'(q.ptr) < NUM_REGS) begin
                                d.we    = 1'b1;
                                d.waddr = q.ptr[AW-1:0];
                                d.wdata = q.sr;
                                d.ptr   = q.ptr + PW'(1);
                                d.oe    = 1'b1;
                                d.st    = ST_DACK;
                            end
                        end
                    end
                end
                ST_AACK: begin
                    if (evt.scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.tx = rd_data;
                            d.oe = ~rd_data[7];
                            d.st = ST_RDATA;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_SUB;
                        end
                    end
                end
                ST_DACK: begin
                    if (evt.scl_fall) begin
                        d.cnt = '0;
                        d.oe  = 1'b0;
                        d.st  = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (evt.scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (evt.scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe  = 1'b0;
                            d.cnt = '0;
                            d.st  = ST_RACK;
                        end else begin
                            d.tx = {q.tx[6:0], 1'b0};
                            d.oe = ~q.tx[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (evt.scl_rise) begin
                        d.mack = evt.sda;
                        if (!evt.sda) begin
                            d.ptr = (int'(q.ptr) >= NUM_REGS - 1) ?
                                    PW'(NUM_REGS - 1) : q.ptr + PW'(1);
                        end
                    end else if (evt.scl_fall) begin
                        if (!q.mack) begin
                            d.tx  = rd_data;
                            d.oe  = ~rd_data[7];
                            d.cnt = '0;
                            d.st  = ST_RDATA;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, sr: '0, tx: '0, ptr: '0, rw: 1'b0,
                   mack: 1'b1, oe: 1'b0, we: 1'b0, waddr: '0, wdata: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_idx = (int'(q.ptr) >= NUM_REGS) ? AW'(NUM_REGS - 1) : q.ptr[AW-1:0];
    assign sda_oe = q.oe;
    assign we     = q.we;
    assign waddr  = q.waddr;
    assign wdata  = q.wdata;

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> !evt.scl);

    // R3
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we);

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> (q.st == ST_IDLE && !q.oe));

    // R9
    start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> (q.st == ST_ADDR && q.cnt == 4'd0 && !q.oe));

endmodule

// File: rtl/i2c_regmap_slave.sv
module i2c_regmap_slave
    import i2c_regmap_pkg::*;
#(
    parameter int         NUM_REGS = 12,
    parameter logic [6:0] DEV_ADDR = 7'h3C,
    parameter int         FILT_LEN = 3,
    localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic          reg_we,
    output logic [AW-1:0] reg_addr,
    output logic [7:0]    reg_wdata
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] clean_lines;
    bus_evt_t          evt;
    logic [7:0]        rd_data;
    logic [AW-1:0]     rd_idx;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) i_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (clean_lines[g])
        );
    end

    i2c_bus_cond i_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_f (clean_lines[1]),
        .sda_f (clean_lines[0]),
        .evt   (evt)
    );

    i2c_slave_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .rd_data (rd_data),
        .rd_idx  (rd_idx),
        .sda_oe  (sda_oe),
        .we      (reg_we),
        .waddr   (reg_addr),
        .wdata   (reg_wdata)
    );

    i2c_regbank #(.NUM_REGS(NUM_REGS)) i_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .waddr (reg_addr),
        .wdata (reg_wdata),
        .raddr (rd_idx),
        .rdata (rd_data)
    );

endmodule

// File: tb/test_i2c_regmap_slave.sv
`timescale 1ns/1ps
module test_i2c_regmap_slave;

    localparam int         N   = 12;
    localparam logic [6:0] DEV = 7'h3C;
    localparam int         Q   = 16;
    localparam int         AW  = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_oe, reg_we;
    logic [AW-1:0] reg_addr;
    logic [7:0] reg_wdata;

    int vectors = 0;
    int errors = 0;
    int expreg[N];
    int ptr = 0;
    bit live = 0;
    int wq_a[$];
    int wq_d[$];
    logic prev_oe = 1'b0;
    logic prev_we = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_regmap_slave #(.NUM_REGS(N), .DEV_ADDR(DEV), .FILT_LEN(3)) i_i2c_regmap_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-clock monitor, 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (sda_oe !== prev_oe) begin
                vectors++;
                if (scl_m) begin
                    errors++;
                    $display("FAIL R10: actual sda_oe change with SCL %0b expected SCL 0", scl_m);
                end
            end
            if (reg_we) begin
                vectors++;
                if (prev_we) begin
                    errors++;
                    $display("FAIL R3: actual strobe width >1 expected 1");
                end else if (wq_a.size() == 0) begin
                    errors++;
                    $display("FAIL R8: actual write %0h<=%0h expected none", reg_addr, reg_wdata);
                end else begin
                    int ea, ed;
                    ea = wq_a.pop_front();
                    ed = wq_d.pop_front();
                    if (int'(reg_addr) != ea || int'(reg_wdata) != ed) begin
                        errors++;
                        $display("FAIL R3: actual %0h<=%0h expected %0h<=%0h",
                                 reg_addr, reg_wdata, ea, ed);
                    end
                end
            end
        end
        prev_oe = sda_oe;
        prev_we = reg_we;
    end

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic send_bit(input bit b, input bit gl, output bit s);
        sda_m = b;
        if (gl) begin
            repeat (Q / 2) @(negedge clk);
            scl_m = 1'b1;
            @(negedge clk);
            scl_m = 1'b0;
            repeat (Q / 2 - 1) @(negedge clk);
        end else begin
            qwait();
        end
        scl_m = 1'b1;
        qwait();
        s = sda_bus;
        qwait();
        scl_m = 1'b0;
        qwait();
    endtask

    task automatic wr_byte(input logic [7:0] b, input bit gl, output bit a);
        bit s;
        for (int i = 7; i >= 0; i--) send_bit(b[i], gl && (i == 4), s);
        send_bit(1'b1, 1'b0, a);
    endtask

    task automatic rd_byte(input bit mack, output logic [7:0] dv);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, 1'b0, s);
            dv[i] = s;
        end
        send_bit(!mack, 1'b0, s);
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            sda_m = 1'b1;
            qwait();
            scl_m = 1'b1;
            qwait();
        end
        sda_m = 1'b0;
        qwait();
        scl_m = 1'b0;
        qwait();
        live = 0;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        qwait();
        scl_m = 1'b1;
        qwait();
        sda_m = 1'b1;
        qwait();
        live = 0;
    endtask

    task automatic addr_ph(input logic [6:0] a, input bit rw, input string req);
        bit k;
        wr_byte({a, rw}, 1'b0, k);
        live = (a == DEV);
        chk(req, int'(k), live ? 0 : 1);
    endtask

    task automatic sub_ph(input int sub, input string req);
        bit k;
        int e;
        wr_byte(8'(sub), 1'b0, k);
        if (live && sub < N) begin
            ptr = sub;
            e = 0;
        end else begin
            live = 0;
            e = 1;
        end
        chk(req, int'(k), e);
    endtask

    task automatic data_w(input int dv, input bit gl, input string req);
        bit k;
        int e;
        if (live && ptr < N) begin
            wq_a.push_back(ptr);
            wq_d.push_back(dv);
            expreg[ptr] = dv;
            ptr++;
            e = 0;
        end else begin
            live = 0;
            e = 1;
        end
        wr_byte(8'(dv), gl, k);
        chk(req, int'(k), e);
    endtask

    task automatic data_r(input bit mack, input string req);
        logic [7:0] dv;
        int idx;
        idx = (ptr > N - 1) ? N - 1 : ptr;
        rd_byte(mack, dv);
        chk(req, int'(dv), expreg[idx]);
        if (mack) ptr = (ptr + 1 > N - 1) ? N - 1 : ptr + 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [7:0] dv;
        bit s;
        for (int i = 0; i < N; i++) expreg[i] = 0;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1", int'(sda_oe), 0);
        chk("R1", int'(reg_we), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R1: registers read as zero
        bus_start(); addr_ph(DEV, 1'b0, "R2"); sub_ph(0, "R3");
        bus_start(); addr_ph(DEV, 1'b1, "R2");
        data_r(1'b1, "R1"); data_r(1'b1, "R1"); data_r(1'b0, "R1");
        bus_stop();

        // R2: wrong address, then no response
        bus_start(); addr_ph(7'h3D, 1'b0, "R2"); data_w(8'h00, 1'b0, "R2");
        bus_stop();

        // R3: write three bytes from subaddress 2
        bus_start(); addr_ph(DEV, 1'b0, "R2"); sub_ph(2, "R3");
        data_w(8'hA5, 1'b0, "R3"); data_w(8'h3C, 1'b0, "R3"); data_w(8'h81, 1'b0, "R3");
        bus_stop();

        // R6: read them back after a repeated start
        bus_start(); addr_ph(DEV, 1'b0, "R2"); sub_ph(2, "R6");
        bus_start(); addr_ph(DEV, 1'b1, "R6");
        data_r(1'b1, "R6"); data_r(1'b1, "R6"); data_r(1'b0, "R6");
        bus_stop();

        // R4: invalid subaddresses
        bus_start(); addr_ph(DEV, 1'b0, "R2"); sub_ph(N, "R4"); data_w(8'h55, 1'b0, "R4");
        bus_stop();
        bus_start(); addr_ph(DEV, 1'b0, "R2"); sub_ph(200, "R4"); data_w(8'h66, 1'b0, "R4");
        bus_stop();

        // R5: write past the top register
        bus_start(); addr_ph(DEV, 1'b0, "R2"); sub_ph(N - 2, "R3");
        data_w(8'h11, 1'b0, "R3"); data_w(8'h22, 1'b0, "R3");
        data_w(8'h33, 1'b0, "R5"); data_w(8'h44, 1'b0, "R5");
        bus_stop();

        // R7: read past the top register, then NACK ends it
        bus_start(); addr_ph(DEV, 1'b0, "R2"); sub_ph(N - 2, "R7");
        bus_start(); addr_ph(DEV, 1'b1, "R7");
        data_r(1'b1, "R7"); data_r(1'b1, "R7"); data_r(1'b1, "R7"); data_r(1'b0, "R7");
        chk("R7", int'(sda_oe), 0);
        rd_byte(1'b1, dv);
        chk("R7", int'(dv), 8'hFF);
        bus_stop();

        // R8: stop in the middle of a data byte
        bus_start(); addr_ph(DEV, 1'b0, "R2"); sub_ph(5, "R8");
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0, s);
        bus_stop();
        bus_start(); addr_ph(DEV, 1'b0, "R2"); sub_ph(5, "R8");
        bus_start(); addr_ph(DEV, 1'b1, "R8");
        data_r(1'b0, "R8");
        bus_stop();

        // R9: start in the middle of the address byte
        bus_start();
        for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0, s);
        bus_start(); addr_ph(DEV, 1'b0, "R9"); sub_ph(7, "R9"); data_w(8'h6E, 1'b0, "R9");
        bus_stop();
        bus_start(); addr_ph(DEV, 1'b0, "R2"); sub_ph(7, "R9");
        bus_start(); addr_ph(DEV, 1'b1, "R9");
        data_r(1'b0, "R9");
        bus_stop();

        // R11: short SCL pulse inside a data byte
        bus_start(); addr_ph(DEV, 1'b0, "R2"); sub_ph(8, "R11"); data_w(8'hC3, 1'b1, "R11");
        bus_stop();
        bus_start(); addr_ph(DEV, 1'b0, "R2"); sub_ph(8, "R11");
        bus_start(); addr_ph(DEV, 1'b1, "R11");
        data_r(1'b0, "R11");
        bus_stop();

        // R6: read from the current subaddress without setting it
        bus_start(); addr_ph(DEV, 1'b1, "R6");
        data_r(1'b1, "R6"); data_r(1'b0, "R6");
        bus_stop();

        repeat (20) @(negedge clk);
        chk("R8", wq_a.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule